// File: doc/BRIEF.md
# Filtered Input-Capture Latch

This block timestamps transitions on an asynchronous capture pin. A running timer value arrives as an input. When the pin makes a transition of the chosen polarity, the block copies that timer value into a capture register and raises a one-clock event pulse. The pin first passes through a synchronizer chain. It then passes through an optional run-length filter, which accepts a new level only after the level has been sampled on several consecutive system clocks. Edges are taken from the filtered level.

Two run-time controls set the behaviour: a polarity bit and a filter-enable bit. A host timer uses the pulse as its capture interrupt source and reads the captured word. Counting, prescaling and interrupt logic belong to the surrounding timer and are not part of this block.

Top module: `ecap_unit`

## Requirements
- R1: With the filter off, a pin change first sampled at clock edge k makes `evt_o` high after edge k+3. The delay comes from two synchronizer flops, one level register and one capture register.
- R2: With the filter off, a pin pulse that is sampled at only one clock edge is accepted as an edge.
- R3: With the filter on, the new level must be sampled at 4 consecutive clock edges before it is accepted. A change first sampled at edge k makes `evt_o` high after edge k+6.
- R4: With the filter on, a pin excursion sampled at fewer than 4 consecutive edges causes no event and leaves `cap_o` unchanged.
- R5: With `edge_rise_i` = 1, only a 0-to-1 change of the filtered level causes a capture.
- R6: With `edge_rise_i` = 0, only a 1-to-0 change of the filtered level causes a capture.
- R7: On a capture, `cap_o` takes the `timer_i` value present during the clock before the edge at which `evt_o` rises. Otherwise `cap_o` holds its value.
- R8: `evt_o` is high for exactly one clock per accepted edge. Accepted edges two clocks apart give separate pulses.
- R9: Changing `edge_rise_i` while the pin is steady produces no event.
- R10: While `rst_i` is high, `cap_o` is 0 and `evt_o` is 0. The synchronizer, the filter history and the level all reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the filter sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| timer_i | input | TW (16) | Running timer value to be captured |
| edge_rise_i | input | 1 | 1: capture on rising edge, 0: on falling edge |
| filt_en_i | input | 1 | 1: enable the 4-sample run-length filter |
| cap_o | output | TW (16) | Capture register |
| evt_o | output | 1 | One-clock pulse per accepted edge |

## Verification
The bench drives the pin with slow full-width transitions of both polarities under both polarity settings. This separates rising-only capture from falling-only capture and measures the fixed latency with the filter on and with it off. Pulses lasting one, two, three and four clocks are applied with the filter on, and a one-clock pulse with it off. These show that the run-length threshold sits exactly at four samples and that the filter-off path accepts the shortest pulse. Toggling the polarity on a steady pin tests for spurious captures. A pin that toggles every clock tests that back-to-back accepted edges give separate single-clock pulses. On every clock, the captured word is compared against a free-running timer.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
   localparam int unsigned ECAP_TW_DEF    = 16;
   localparam int unsigned ECAP_SYNC_DEF  = 2;
   localparam int unsigned ECAP_FILT_DEF  = 4;

   typedef enum logic {
      ECAP_FALL = 1'b0,
      ECAP_RISE = 1'b1
   } ecap_pol_e;

   // returns 1 when a level change matches the requested polarity
   function automatic logic ecap_hit(input logic lvl_now, input logic lvl_old,
                                     input ecap_pol_e pol);
      return (lvl_now != lvl_old) && (lvl_now == logic'(pol));
   endfunction
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ecap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_filter.sv
module ecap_filter #(
   parameter int unsigned FILT_LEN = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic smp_i,
   input  logic filt_en_i,
   output logic lvl_o
);
   localparam int unsigned HLEN = FILT_LEN - 1;

   generate
      if (FILT_LEN < 2) begin : g_bad_len
         $error("ecap_filter: FILT_LEN must be at least 2");
      end
   endgenerate

   logic [HLEN-1:0] hist_q;
   logic [FILT_LEN-1:0] window;
   logic all_hi, all_lo, lvl_q, lvl_d;

   // history of earlier samples; the register shape depends on its length
   generate
      if (HLEN == 1) begin : g_hist_one
         always_ff @(posedge clk_i) begin
            if (rst_i) hist_q <= '0;
            else       hist_q <= smp_i;
         end
      end else begin : g_hist_shift
         always_ff @(posedge clk_i) begin
            if (rst_i) hist_q <= '0;
            else       hist_q <= {hist_q[HLEN-2:0], smp_i};
         end
      end
   endgenerate

   assign window = {hist_q, smp_i};
   assign all_hi = &window;
   assign all_lo = ~|window;

   always_comb begin
      lvl_d = lvl_q;
      if (!filt_en_i) begin
         lvl_d = smp_i;
      end else if (all_hi) begin
         lvl_d = 1'b1;
      end else if (all_lo) begin
         lvl_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) lvl_q <= 1'b0;
      else       lvl_q <= lvl_d;
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/ecap_latch.sv
module ecap_latch
   import ecap_pkg::*;
#(
   parameter int unsigned TW = 16
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          lvl_i,
   input  ecap_pol_e     pol_i,
   input  logic [TW-1:0] timer_i,
   output logic [TW-1:0] cap_o,
   output logic          evt_o
);
   logic          prev_q;
   logic          hit;
   logic [TW-1:0] cap_q;
   logic          evt_q;

   assign hit = ecap_hit(lvl_i, prev_q, pol_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q <= 1'b0;
         evt_q  <= 1'b0;
         cap_q  <= '0;
      end else begin
         prev_q <= lvl_i;
         evt_q  <= hit;
         if (hit) cap_q <= timer_i;
      end
   end

   assign cap_o = cap_q;
   assign evt_o = evt_q;
endmodule

// File: rtl/ecap_unit.sv
module ecap_unit
   import ecap_pkg::*;
#(
   parameter int unsigned TW          = ECAP_TW_DEF,
   parameter int unsigned SYNC_STAGES = ECAP_SYNC_DEF,
   parameter int unsigned FILT_LEN    = ECAP_FILT_DEF
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          cap_pin_i,
   input  logic [TW-1:0] timer_i,
   input  logic          edge_rise_i,
   input  logic          filt_en_i,
   output logic [TW-1:0] cap_o,
   output logic          evt_o
);
   generate
      if (TW < 1) begin : g_bad_tw
         $error("ecap_unit: TW must be positive");
      end
   endgenerate

   logic sync_w;
   logic lvl_w;
   ecap_pol_e pol_w;

   assign pol_w = ecap_pol_e'(edge_rise_i);

   ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (cap_pin_i),
      .q_o   (sync_w)
   );

   ecap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .smp_i     (sync_w),
      .filt_en_i (filt_en_i),
      .lvl_o     (lvl_w)
   );

   ecap_latch #(.TW(TW)) u_latch (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .lvl_i   (lvl_w),
      .pol_i   (pol_w),
      .timer_i (timer_i),
      .cap_o   (cap_o),
      .evt_o   (evt_o)
   );
endmodule

// File: rtl/ecap_unit_chk.sv
module ecap_unit_chk #(
   parameter int unsigned TW       = 16,
   parameter int unsigned FILT_LEN = 4
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [TW-1:0] timer_i,
   input logic          edge_rise_i,
   input logic          filt_en_i,
   input logic [TW-1:0] cap_o,
   input logic          evt_o,
   input logic          sync_s,
   input logic          lvl_s
);
   localparam int unsigned RW = $clog2(FILT_LEN + 1);

   logic          last_q;
   logic [RW-1:0] run_q;
   logic [RW-1:0] cur_run;
   logic          lvl_old_q;

   assign cur_run = (sync_s != last_q) ? RW'(1) :
                    (run_q >= RW'(FILT_LEN)) ? RW'(FILT_LEN) : run_q + RW'(1);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         last_q    <= 1'b0;
         run_q     <= RW'(FILT_LEN - 1);
         lvl_old_q <= 1'b0;
      end else begin
         last_q    <= sync_s;
         run_q     <= cur_run;
         lvl_old_q <= lvl_s;
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk_i) rst_i |=> (cap_o == '0 && !evt_o)); // R10

   AST_CAP_TAKES_TIMER: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_o |-> cap_o == $past(timer_i)); // R7

   AST_CAP_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      !evt_o |-> $stable(cap_o)); // R7

   AST_EVT_POLARITY: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_o |-> ($past(lvl_s) == $past(edge_rise_i) && $past(lvl_s) != $past(lvl_old_q))); // R5

   AST_FILTER_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(filt_en_i) && lvl_s != $past(lvl_s)) |-> $past(cur_run) >= RW'(FILT_LEN)); // R4

   AST_NO_SPURIOUS_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
      (lvl_s == lvl_old_q) |=> !evt_o); // R9
endmodule

bind ecap_unit ecap_unit_chk #(.TW(TW), .FILT_LEN(FILT_LEN)) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .timer_i     (timer_i),
   .edge_rise_i (edge_rise_i),
   .filt_en_i   (filt_en_i),
   .cap_o       (cap_o),
   .evt_o       (evt_o),
   .sync_s      (sync_w),
   .lvl_s       (lvl_w)
);

// File: tb/ecap_unit_bench.sv
`timescale 1ns/1ps
module ecap_unit_bench;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pin = 1'b0;
   logic [TW-1:0] timer = '0;
   logic          sel = 1'b1;
   logic          filt = 1'b0;
   logic [TW-1:0] cap;
   logic          evt;

   int vecs = 0;
   int bad = 0;
   int evt_cnt = 0;
   bit done = 0;
   string cur_req = "R10";

   always #2 clk = ~clk;

   ecap_unit u_ecap_unit (
      .clk_i(clk), .rst_i(rst), .cap_pin_i(pin), .timer_i(timer),
      .edge_rise_i(sel), .filt_en_i(filt), .cap_o(cap), .evt_o(evt)
   );

   // behavioural reference: history of pin samples, newest first
   int smp[0:7];
   int m_lvl, m_prev, m_evt;
   int m_cap;

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 8; i++) smp[i] = 0;
         m_lvl = 0; m_prev = 0; m_evt = 0; m_cap = 0;
      end else begin
         m_evt = (m_lvl != m_prev && m_lvl == int'(sel)) ? 1 : 0;
         if (m_evt == 1) m_cap = int'(timer);
         m_prev = m_lvl;
         if (!filt) m_lvl = smp[1];
         else if (smp[1] == smp[2] && smp[2] == smp[3] && smp[3] == smp[4]) m_lvl = smp[1];
         for (int i = 7; i > 0; i--) smp[i] = smp[i-1];
         smp[0] = int'(pin);
      end
   end

   always @(negedge clk) begin
      timer <= timer + 16'h0101;
      vecs++;
      if (int'(evt) != m_evt || int'(cap) != m_cap) begin
         bad++;
         $display("FAIL %s: evt=%0d cap=%h expected evt=%0d cap=%h", cur_req, evt, cap, m_evt, m_cap[TW-1:0]);
      end
      if (evt) evt_cnt++;
   end

   task automatic chk(input int act, input int exp, input string req);
      vecs++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drive the pin to lvl right after a negedge and count negedges to the pulse
   task automatic latency(input logic lvl, input int exp, input string req);
      int n = 0;
      @(negedge clk);
      pin = lvl;
      do begin
         @(negedge clk);
         #0.1;
         n++;
      end while (!evt && n < 20);
      chk(n, exp, req);
   endtask

   task automatic pulse(input int w);
      @(negedge clk);
      pin = 1'b1;
      wait_cyc(w);
      pin = 1'b0;
      wait_cyc(12);
   endtask

   initial begin
      int base;
      bit dbl;
      wait_cyc(4);
      #0.1;
      chk(int'(cap), 0, "R10");
      chk(int'(evt), 0, "R10");
      @(negedge clk); rst = 1'b0;
      wait_cyc(4);

      // unfiltered, rising polarity
      cur_req = "R5"; sel = 1'b1; filt = 1'b0;
      base = evt_cnt;
      latency(1'b1, 4, "R1");
      wait_cyc(10);
      @(negedge clk); pin = 1'b0;
      wait_cyc(10);
      chk(evt_cnt - base, 1, "R5");

      // unfiltered, falling polarity
      cur_req = "R6"; sel = 1'b0;
      wait_cyc(2);
      base = evt_cnt;
      @(negedge clk); pin = 1'b1;
      wait_cyc(10);
      latency(1'b0, 4, "R6");
      wait_cyc(6);
      chk(evt_cnt - base, 1, "R6");

      // single-sample pulse, filter off
      cur_req = "R2"; sel = 1'b1;
      base = evt_cnt;
      pulse(1);
      chk(evt_cnt - base, 1, "R2");

      // filtered short glitches
      cur_req = "R4"; filt = 1'b1;
      wait_cyc(4);
      base = evt_cnt;
      pulse(1); pulse(2); pulse(3);
      chk(evt_cnt - base, 0, "R4");
      chk(int'(cap), m_cap, "R4");

      // filtered full-length change
      cur_req = "R3";
      latency(1'b1, 7, "R3");
      wait_cyc(6);
      @(negedge clk); pin = 1'b0;
      wait_cyc(12);
      base = evt_cnt;
      pulse(4);
      chk(evt_cnt - base, 1, "R3");

      // polarity changes on a steady pin
      cur_req = "R9"; filt = 1'b0; sel = 1'b0;
      @(negedge clk); pin = 1'b1;
      wait_cyc(8);
      base = evt_cnt;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); sel = ~sel;
         wait_cyc(2);
      end
      wait_cyc(6);
      chk(evt_cnt - base, 0, "R9");

      // back-to-back accepted edges
      cur_req = "R8"; sel = 1'b0;
      @(negedge clk); pin = 1'b0;
      wait_cyc(8);
      sel = 1'b1;
      wait_cyc(2);
      base = evt_cnt;
      dbl = 0;
      fork
         begin
            for (int i = 0; i < 20; i++) begin
               @(negedge clk); pin = ~pin;
            end
         end
         begin
            for (int i = 0; i < 28; i++) begin
               @(negedge clk); #0.1;
               if (evt) begin
                  @(negedge clk); #0.1;
                  if (evt) dbl = 1;
                  i++;
               end
            end
         end
      join
      wait_cyc(6);
      chk(evt_cnt - base, 10, "R8");
      chk(int'(dbl), 0, "R8");

      cur_req = "R7";
      wait_cyc(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end
endmodule